// File: doc/BRIEF.md
# Bit-Serial Adder

This block adds two unsigned operands one bit position per clock, using a single full adder instead of a full-width carry chain. Both operands are loaded in parallel into two right-shifting registers. On every enabled step the least-significant bits of the two registers and a stored carry enter the full adder. The sum bit shifts into the top of the augend register while that register's old contents leave at the bottom. The new carry is held in a one-bit flip-flop for the next position. After as many enabled steps as the operand width, the augend register holds the sum and the carry flip-flop holds the carry-out.

The addend register has its own serial input. A new addend can therefore be streamed in, lowest bit first, while the current addition runs. A following addition can then combine the previous sum with that streamed value, with no parallel reload. The step enable is a synchronous clock enable, not a gated clock. A step counter raises a done flag once a full word of steps has been taken since the last clear. The default width is four bits.

Top module: `bit_serial_adder`

## Requirements
- R1: While `rst` is high at a clock edge, the sum register, the addend register, the carry flip-flop, the step counter and `done_o` all become 0.
- R2: When `load` is high, the next edge copies `a_in` into the sum register and `b_in` into the addend register. No shift happens in that cycle, whatever `shift_en` is, and the carry and step counter are left to `clr`.
- R3: When `clr` is high, the next edge sets the carry flip-flop and the step counter to 0, so `done_o` is 0. The sum register keeps its value unless `load` is also high, and no shift happens in that cycle.
- R4: A step happens when `shift_en` is high and both `load` and `clr` are low. In a step, the sum register shifts right by one bit and takes at its MSB the XOR of its old bit 0, the addend's bit 0 and the stored carry. The carry flip-flop takes the majority of those same three bits.
- R5: A step is preceded by `load` of a and b together with `clr`. After exactly WIDTH steps (4 by default) from then, with any number of idle cycles between the steps, `sum_o` equals (a+b) mod 2^WIDTH and `carry_o` equals bit WIDTH of a+b.
- R6: In a cycle where `shift_en`, `load` and `clr` are all low, `sum_o`, `carry_o` and `done_o` keep their values.
- R7: In every step, the addend register shifts right and takes `b_ser_in` at its MSB. After WIDTH steps, the bit sent first sits at bit 0. Following a `clr` with no `load`, another WIDTH steps then produce (previous sum + streamed value) at `sum_o` and `carry_o`.
- R8: `done_o` is 0 after fewer than WIDTH steps since the last clear or reset. It becomes 1 at the edge of the WIDTH-th step and stays 1 through further steps, idle cycles and loads, until the next `clr` or `rst`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Synchronous clear of carry and step counter |
| load | input | 1 | Parallel load of both operand registers |
| a_in | input | WIDTH | Augend value for parallel load |
| b_in | input | WIDTH | Addend value for parallel load |
| shift_en | input | 1 | Step enable |
| b_ser_in | input | 1 | Serial input at the addend register's MSB |
| sum_o | output | WIDTH | Sum/augend register contents |
| carry_o | output | 1 | Carry flip-flop (carry-out after the last step) |
| done_o | output | 1 | A full word of steps has been taken since the last clear |

## Verification
The bound checker checks the local rules of the block on every cycle. These are the one-bit step relation between the old register bits and the new sum bit and carry, the hold of all outputs when idle, the load taking the parallel value, the clear zeroing the carry and the flag, and the flag not dropping without a clear. Only the bench's scenarios can show the word-level result: that WIDTH steps yield the correct sum and carry-out for every pair of 4-bit operands, with and without idle gaps. The bench scenarios also show that a streamed addend is assembled in the right bit order and that the flag rises on exactly the last step.

// File: rtl/bsa_pkg.sv
package bsa_pkg;
  function automatic logic fa_sum(input logic x, input logic y, input logic z);
    return x ^ y ^ z;
  endfunction

  function automatic logic fa_carry(input logic x, input logic y, input logic z);
    return (x & y) | (x & z) | (y & z);
  endfunction
endpackage

// File: rtl/bsa_shreg.sv
module bsa_shreg #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [WIDTH-1:0] load_val,
  input  logic             step,
  input  logic             ser_in,
  output logic [WIDTH-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else if (load) begin
      q <= load_val;
    end else if (step) begin
      q <= {ser_in, q[WIDTH-1:1]};
    end
  end
endmodule

// File: rtl/bsa_full_adder.sv
module bsa_full_adder
  import bsa_pkg::*;
(
  input  logic x,
  input  logic y,
  input  logic z,
  output logic s,
  output logic co
);
  always_comb begin
    s  = fa_sum(x, y, z);
    co = fa_carry(x, y, z);
  end
endmodule

// File: rtl/bsa_carry_ff.sv
module bsa_carry_ff (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic step,
  input  logic d,
  output logic q
);
  always_ff @(posedge clk) begin
    if (rst || clr) begin
      q <= 1'b0;
    end else if (step) begin
      q <= d;
    end
  end
endmodule

// File: rtl/bsa_step_ctr.sv
module bsa_step_ctr #(
  parameter int WIDTH = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic step,
  output logic done
);
  localparam int CW = $clog2(WIDTH + 1);
  localparam logic [CW-1:0] LAST = CW'(WIDTH);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (step && (cnt_q != LAST)) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt_q <= '0;
      done  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      done  <= (cnt_d == LAST);
    end
  end
endmodule

// File: rtl/bit_serial_adder.sv
module bit_serial_adder #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             load,
  input  logic [WIDTH-1:0] a_in,
  input  logic [WIDTH-1:0] b_in,
  input  logic             shift_en,
  input  logic             b_ser_in,
  output logic [WIDTH-1:0] sum_o,
  output logic             carry_o,
  output logic             done_o
);
  logic             step;
  logic [WIDTH-1:0] a_q;
  logic [WIDTH-1:0] b_q;
  logic             fa_s;
  logic             fa_co;
  logic             carry_q;

  assign step = shift_en && !load && !clr;

  bsa_shreg #(.WIDTH(WIDTH)) u_areg (
    .clk(clk), .rst(rst), .load(load), .load_val(a_in),
    .step(step), .ser_in(fa_s), .q(a_q)
  );

  bsa_shreg #(.WIDTH(WIDTH)) u_breg (
    .clk(clk), .rst(rst), .load(load), .load_val(b_in),
    .step(step), .ser_in(b_ser_in), .q(b_q)
  );

  bsa_full_adder u_fa (
    .x(a_q[0]), .y(b_q[0]), .z(carry_q), .s(fa_s), .co(fa_co)
  );

  bsa_carry_ff u_cff (
    .clk(clk), .rst(rst), .clr(clr), .step(step), .d(fa_co), .q(carry_q)
  );

  bsa_step_ctr #(.WIDTH(WIDTH)) u_ctr (
    .clk(clk), .rst(rst), .clr(clr), .step(step), .done(done_o)
  );

  assign sum_o   = a_q;
  assign carry_o = carry_q;
endmodule

// File: rtl/bit_serial_adder_chk.sv
module bit_serial_adder_chk #(
  parameter int WIDTH = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             clr,
  input logic             load,
  input logic [WIDTH-1:0] a_in,
  input logic             shift_en,
  input logic [WIDTH-1:0] sum_o,
  input logic             carry_o,
  input logic             done_o,
  input logic             b_lsb
);
  // R1
  reset_clears_chk: assert property (@(posedge clk)
    rst |=> (sum_o == '0) && !carry_o && !done_o);

  // R2
  load_value_chk: assert property (@(posedge clk) disable iff (rst)
    load |=> sum_o == $past(a_in));

  // R3
  clear_zero_chk: assert property (@(posedge clk) disable iff (rst)
    clr |=> !carry_o && !done_o);

  // R3
  clear_keeps_sum_chk: assert property (@(posedge clk) disable iff (rst)
    (clr && !load) |=> $stable(sum_o));

  // R4
  step_sum_chk: assert property (@(posedge clk) disable iff (rst)
    (shift_en && !load && !clr) |=>
      sum_o == {($past(sum_o[0]) ^ $past(b_lsb) ^ $past(carry_o)), $past(sum_o[WIDTH-1:1])});

  // R4
  step_carry_chk: assert property (@(posedge clk) disable iff (rst)
    (shift_en && !load && !clr) |=>
      carry_o == (($past(sum_o[0]) && $past(b_lsb)) || ($past(sum_o[0]) && $past(carry_o))
                  || ($past(b_lsb) && $past(carry_o))));

  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!shift_en && !load && !clr) |=> $stable(sum_o) && $stable(carry_o) && $stable(done_o));

  // R8
  done_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (done_o && !clr) |=> done_o);
endmodule

bind bit_serial_adder bit_serial_adder_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst(rst), .clr(clr), .load(load), .a_in(a_in),
  .shift_en(shift_en), .sum_o(sum_o), .carry_o(carry_o),
  .done_o(done_o), .b_lsb(b_q[0])
);

// File: tb/bit_serial_adder_bench.sv
module bit_serial_adder_bench;
  localparam int W = 4;

  logic         clk = 1'b0;
  logic         rst, clr, load, shift_en, b_ser_in;
  logic [W-1:0] a_in, b_in;
  logic [W-1:0] sum_o;
  logic         carry_o, done_o;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  bit_serial_adder #(.WIDTH(W)) u_bit_serial_adder (
    .clk(clk), .rst(rst), .clr(clr), .load(load), .a_in(a_in), .b_in(b_in),
    .shift_en(shift_en), .b_ser_in(b_ser_in), .sum_o(sum_o),
    .carry_o(carry_o), .done_o(done_o)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Drive one cycle: inputs set at negedge, results visible at next negedge.
  task automatic cyc(input logic r, input logic c, input logic l, input logic s, input logic bs);
    rst = r; clr = c; load = l; shift_en = s; b_ser_in = bs;
    @(negedge clk);
  endtask

  initial begin
    a_in = '0; b_in = '0;
    @(negedge clk);
    cyc(1, 0, 0, 0, 0);
    cyc(1, 0, 0, 0, 0);
    // R1 reset state
    check("R1 sum", int'(sum_o), 0);
    check("R1 carry", int'(carry_o), 0);
    check("R1 done", int'(done_o), 0);

    for (int a = 0; a < 16; a++) begin
      for (int b = 0; b < 16; b++) begin
        int nb;
        int s1;
        int s2;
        nb = (a * 5 + b * 3 + 7) % 16;
        a_in = W'(a); b_in = W'(b);
        cyc(0, 1, 1, (a % 2 == 1), 0);
        // R2 load wins over shift_en
        check("R2 load", int'(sum_o), a);
        check("R3 done cleared", int'(done_o), 0);
        for (int k = 0; k < W; k++) begin
          cyc(0, 0, 0, 1, nb[k]);
          if ((a + b) % 3 == 0) begin
            cyc(0, 0, 0, 0, 1'b1);
          end
          if (k == W - 2) check("R8 done low early", int'(done_o), 0);
        end
        s1 = a + b;
        // R5 result after W steps
        check("R5 sum", int'(sum_o), s1 % 16);
        check("R5 carry", int'(carry_o), s1 / 16);
        check("R8 done", int'(done_o), 1);
        // R6 idle hold
        cyc(0, 0, 0, 0, 1);
        check("R6 hold", int'(sum_o) + 32 * int'(carry_o), (s1 % 16) + 32 * (s1 / 16));
        // R3 clear keeps sum, zeroes carry, suppresses shift
        cyc(0, 1, 0, 1, 0);
        check("R3 sum kept", int'(sum_o), s1 % 16);
        check("R3 carry", int'(carry_o), 0);
        // R7 second addition using streamed addend
        for (int k = 0; k < W; k++) cyc(0, 0, 0, 1, 0);
        s2 = (s1 % 16) + nb;
        check("R7 sum", int'(sum_o), s2 % 16);
        check("R7 carry", int'(carry_o), s2 / 16);
        // R8 done sticky through extra step
        cyc(0, 0, 0, 1, 0);
        check("R8 sticky", int'(done_o), 1);
      end
    end

    // R4 single step from known state: a=1011, b=0011, carry 0
    a_in = 4'b1011; b_in = 4'b0011;
    cyc(0, 1, 1, 0, 0);
    cyc(0, 0, 0, 1, 1);
    check("R4 step sum", int'(sum_o), 4'b0101);
    check("R4 step carry", int'(carry_o), 1);
    // R1 reset mid-operation
    cyc(1, 0, 0, 1, 1);
    check("R1 mid sum", int'(sum_o), 0);
    check("R1 mid carry", int'(carry_o), 0);
    rst = 0;

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule